// File: doc/BRIEF.md
# Dead-Time Inserter with Encoded Duration

This block turns one reference PWM waveform into a pair of complementary drive signals for a half bridge. The high-side output follows the reference with its rising edge held back by a dead time. The low-side output follows the inverted reference, and its rising edge is held back in the same way. Both outputs drop at once when their own phase ends. As a result, the two switches are never commanded on together.

The dead time is set by an 8-bit code that covers four ranges, each with its own step size. Short delays use a fine step and long delays use a coarse one. The code gives a number of dead-time ticks. A 2-bit divider select scales one tick to 1, 2 or 4 kernel clocks. The block converts the code and the divider into a single 12-bit count of kernel cycles. It captures that count at every reference edge, so a later change of code or divider affects only later edges.

Top module: `deadband_pair`

## Requirements
- R1: For codes with bit 7 equal to 0, the dead time is code[6:0] ticks (0 to 127).
- R2: For codes with bits [7:6] equal to 2'b10, the dead time is 2 × (64 + code[5:0]) ticks.
- R3: For codes with bits [7:5] equal to 3'b110, the dead time is 8 × (32 + code[4:0]) ticks.
- R4: For codes with bits [7:5] equal to 3'b111, the dead time is 16 × (32 + code[4:0]) ticks.
- R5: One tick lasts 1 kernel clock for divider select 2'b00, 2 for 2'b01, 4 for 2'b10 and 1 for 2'b11. The dead time in kernel cycles (D) is ticks × that factor, and never exceeds 4032.
- R6: Suppose the clock edge k is the first to sample the reference high. The complementary output is low after edge k, and the main output goes high after edge k + D.
- R7: Suppose the clock edge k is the first to sample the reference low. The main output is low after edge k, and the complementary output goes high after edge k + D.
- R8: The main and complementary outputs are never high in the same cycle.
- R9: A reference phase that lasts D sampled edges or fewer never raises the output belonging to that phase.
- R10: With D = 0, the main output equals the reference sampled at the previous edge, and the complementary output equals its inverse.
- R11: D is captured at each reference edge. A change of code or divider while a dead time is running does not alter that dead time.
- R12: While the enable is low, both outputs are low from the next edge on. The first enabled edge counts as an edge of the current reference level, so that level's output rises D edges later.
- R13: During and right after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output enable for the pair |
| pwm_ref | input | 1 | Reference PWM waveform |
| dt_code | input | 8 | Encoded dead-time value |
| tick_div | input | 2 | Tick length select: 00 ×1, 01 ×2, 10 ×4, 11 ×1 |
| drv_hi | output | 1 | Main (high-side) output |
| drv_lo | output | 1 | Complementary (low-side) output |

## Verification
A fault in the range decode or the divider scaling shows up as a rising edge that arrives early or late. The error is visible on the first edge that uses the affected code, and it can be as large as several thousand cycles in the coarse ranges. A counter that fails to reload, or a stale captured level, shows up as an output that never rises, rises in the wrong phase, or overlaps the other output. A bench model that tracks run lengths of the reference exposes this within one reference period. A wrong enable or arming state makes both outputs stick low after enable, which is visible within D + 1 cycles.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int DTG_CODE_W = 8;
    localparam int DTG_DIV_W  = 2;
    localparam int DTG_CNT_W  = 12;
    localparam logic [DTG_CNT_W-1:0] DTG_MAX_CYC = 12'd4032;

    typedef enum logic [DTG_DIV_W-1:0] {
        DIV_X1   = 2'b00,
        DIV_X2   = 2'b01,
        DIV_X4   = 2'b10,
        DIV_RSVD = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic                 arm;
        logic                 lvl;
        logic [DTG_CNT_W-1:0] cnt;
        logic                 hi;
        logic                 lo;
    } dtg_state_t;
endpackage

// File: rtl/dtg_decode.sv
module dtg_decode
    import dtg_pkg::*;
(
    input  logic [DTG_CODE_W-1:0] code_i,
    input  logic [DTG_DIV_W-1:0]  div_i,
    output logic [DTG_CNT_W-1:0]  cycles_o
);
    logic [DTG_CNT_W-1:0] ticks;

    // Range select on the top code bits; each range has its own step.
    always_comb begin
        casez (code_i[7:5])
            3'b0??:  ticks = {4'b0000, code_i};                    // R1
            3'b10?:  ticks = {4'b0000, 1'b1, code_i[5:0], 1'b0};   // R2
            3'b110:  ticks = {3'b000, 1'b1, code_i[4:0], 3'b000};  // R3
            default: ticks = {2'b00, 1'b1, code_i[4:0], 4'b0000};  // R4
        endcase
    end

    // Tick length in kernel clocks; reserved select behaves as x1.
    always_comb begin
        case (div_sel_e'(div_i))
            DIV_X2:  cycles_o = ticks << 1;
            DIV_X4:  cycles_o = ticks << 2;
            default: cycles_o = ticks;
        endcase
    end
endmodule

// File: rtl/dtg_core.sv
module dtg_core
    import dtg_pkg::*;
#(
    parameter int CNT_W = DTG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ref_i,
    input  logic [CNT_W-1:0] dt_cycles_i,
    output logic             main_o,
    output logic             comp_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    dtg_state_t st_q, st_d;
    logic       edge_hit;
    logic       no_delay;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = ref_i;
        edge_hit = !st_q.arm || (ref_i != st_q.lvl);
        no_delay = (dt_cycles_i == '0);
        if (!en_i) begin
            st_d.arm = 1'b0;
            st_d.cnt = '0;
            st_d.hi  = 1'b0;
            st_d.lo  = 1'b0;
        end else if (edge_hit) begin
            // Capture the delay; the leaving phase drops at once.
            st_d.arm = 1'b1;
            st_d.cnt = no_delay ? '0 : dt_cycles_i;
            st_d.hi  = ref_i && no_delay;
            st_d.lo  = !ref_i && no_delay;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE) begin
                st_d.hi = st_q.lvl;
                st_d.lo = !st_q.lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_o = st_q.hi;
    assign comp_o = st_q.lo;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_o && comp_o)); // R8
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!main_o && !comp_o)); // R12
    AST_MAIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_i) |=> !main_o); // R7
    AST_COMP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_i) |=> !comp_o); // R6
    AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.arm && st_q.cnt == '0 && dt_cycles_i == '0)
        |=> (main_o == $past(ref_i) && comp_o == !$past(ref_i))); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DTG_MAX_CYC); // R5
endmodule

// File: rtl/deadband_pair.sv
module deadband_pair
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pwm_ref,
    input  logic [7:0] dt_code,
    input  logic [1:0] tick_div,
    output logic       drv_hi,
    output logic       drv_lo
);
    logic [DTG_CNT_W-1:0] dt_cycles;

    dtg_decode u_decode (
        .code_i   (dt_code),
        .div_i    (tick_div),
        .cycles_o (dt_cycles)
    );

    dtg_core #(.CNT_W(DTG_CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .ref_i       (pwm_ref),
        .dt_cycles_i (dt_cycles),
        .main_o      (drv_hi),
        .comp_o      (drv_lo)
    );
endmodule

// File: tb/sim_deadband_pair.sv
`timescale 1ns/1ps
module sim_deadband_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       pwm_ref = 1'b0;
    logic [7:0] dt_code = 8'd0;
    logic [1:0] tick_div = 2'd0;
    logic       drv_hi, drv_lo;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    fin = 1'b0;
    string phase = "R13";

    always #2.5 clk = ~clk;

    deadband_pair u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_ref(pwm_ref),
        .dt_code(dt_code), .tick_div(tick_div),
        .drv_hi(drv_hi), .drv_lo(drv_lo)
    );

    // Dead time in kernel cycles, from the range rules written arithmetically.
    function automatic int dec(input int c, input int s);
        int t;
        if (c < 128)      t = c;
        else if (c < 192) t = 2 * (c - 64);
        else if (c < 224) t = 8 * (c - 160);
        else              t = 16 * (c - 192);
        if (s == 1)      return t * 2;
        else if (s == 2) return t * 4;
        return t;
    endfunction

    task automatic chk(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    // Run-length model: an output is high once its level has held for D+1 edges.
    int  run = 0;
    int  dl = 0;
    bit  lvl = 1'b0;
    bit  exp_hi = 1'b0, exp_lo = 1'b0;
    always @(posedge clk) begin
        if (!rst_n || !en) begin
            run = 0;
            exp_hi <= 1'b0;
            exp_lo <= 1'b0;
        end else begin
            if (run == 0 || pwm_ref != lvl) begin
                lvl = pwm_ref;
                run = 1;
                dl  = dec(int'(dt_code), int'(tick_div));
            end else if (run < 100000) begin
                run++;
            end
            exp_hi <= lvl && (run >= dl + 1);
            exp_lo <= !lvl && (run >= dl + 1);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(phase, {30'd0, drv_hi, drv_lo}, {30'd0, exp_hi, exp_lo});
            chk("R8", int'(drv_hi && drv_lo), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Measures delay of both rising edges in negedges after the reference change.
    task automatic measure(input string tag, input int c, input int s);
        int n;
        int d;
        d = dec(c, s);
        phase = tag;
        dt_code = 8'(c); tick_div = 2'(s); en = 1'b1; pwm_ref = 1'b0;
        cyc(d + 4);
        pwm_ref = 1'b1;
        n = 0;
        while (!drv_hi && n < 5000) begin cyc(1); n++; end
        chk(tag, n, d + 1);
        pwm_ref = 1'b0;
        n = 0;
        while (!drv_lo && n < 5000) begin cyc(1); n++; end
        chk(tag, n, d + 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!fin) begin
            fin = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seg;
        void'($urandom(32'd20240611));
        cyc(3);
        chk("R13", int'(drv_hi) + int'(drv_lo), 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R13", int'(drv_hi) + int'(drv_lo), 0);

        // Range and divider corners
        measure("R1", 5, 0);    measure("R1", 127, 0);  measure("R1", 1, 0);
        measure("R2", 128, 0);  measure("R2", 191, 0);
        measure("R3", 192, 0);  measure("R3", 223, 0);
        measure("R4", 224, 0);  measure("R4", 255, 0);
        measure("R5", 10, 1);   measure("R5", 10, 2);   measure("R5", 10, 3);
        measure("R5", 255, 2);
        measure("R10", 0, 0);
        measure("R6", 40, 0);
        measure("R7", 3, 1);

        // Short pulse is swallowed
        phase = "R9"; dt_code = 8'd20; tick_div = 2'd0; pwm_ref = 1'b0; cyc(30);
        pwm_ref = 1'b1; cyc(20); pwm_ref = 1'b0; cyc(1);
        chk("R9", int'(drv_hi), 0);
        cyc(30);
        pwm_ref = 1'b1; cyc(21);
        chk("R9", int'(drv_hi), 1);

        // Code change mid-count does not alter the running dead time
        begin
            int n;
            phase = "R11"; dt_code = 8'd30; pwm_ref = 1'b0; cyc(40);
            pwm_ref = 1'b1; cyc(3); dt_code = 8'd0; tick_div = 2'd2;
            n = 3;
            while (!drv_hi && n < 5000) begin cyc(1); n++; end
            chk("R11", n, 31);
        end

        // Enable behaviour
        phase = "R12"; tick_div = 2'd0; dt_code = 8'd3; pwm_ref = 1'b1; cyc(10);
        en = 1'b0; cyc(1);
        chk("R12", int'(drv_hi) + int'(drv_lo), 0);
        cyc(5);
        en = 1'b1; cyc(3);
        chk("R12", int'(drv_hi), 0);
        cyc(1);
        chk("R12", int'(drv_hi), 1);

        // Zero delay with fast toggling
        phase = "R10"; dt_code = 8'd0;
        for (int i = 0; i < 200; i++) begin
            pwm_ref = 1'($urandom % 2); cyc(1);
        end

        // Constrained random mix
        phase = "R6";
        for (int i = 0; i < 600; i++) begin
            seg = int'($urandom % 100);
            if (seg < 70)      dt_code = 8'($urandom % 40);
            else if (seg < 90) dt_code = 8'($urandom % 256);
            if (seg % 7 == 0)  tick_div = 2'($urandom % 4);
            en = (seg != 3);
            pwm_ref = ~pwm_ref;
            phase = pwm_ref ? "R6" : "R7";
            cyc(1 + int'($urandom % 60));
        end
        en = 1'b1;
        cyc(10);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule